// File: doc/BRIEF.md
# Serial Bit Shifter with Read-Back Voting

This block moves a requested number of bits across a three-wire serial link to a programmable logic device. The three wires are a clock it drives, a data line it drives, and a data line it reads. A sequencer above it supplies a bit count, a parallel word and a bit-order choice, then pulses `start`. The engine runs one bit period per bit and fills a parallel read-back register in arrival order. It pulses `done` when the last clock rise has been issued. Row framing and command selection stay with the sequencer.

The serial clock rests high. In every bit period the engine reads the device's output near the end of the high phase, pulls the clock low, updates its own data line one system clock later, and then raises the clock again. The device takes the data on that rising edge. The length of each phase is a parameter counted in system clocks. It must be set so that each phase lasts at least 10 µs.

Some bits read back wrongly from the device. A bit may echo the data line while the clock is low, or it may stay stuck at a false level until the data line moves. For these cases a triple-sample mode adds a second low phase. During the first low phase the engine drives its data line high and samples. During the second it drives the line low and samples again. A vote over the three samples then gives the bit's value.

Top module: `ser_shift_engine`

## Requirements
- R1: After reset, and whenever no transfer is running, `sclk` is high and `done` is low. Reset also clears `sdi` and `rd_bits` to 0.
- R2: A `start` pulse is accepted only when the engine is idle and `bit_count` is between 1 and MAX_BITS. `bit_count`, `load_word`, `msb_first` and `triple_mode` are captured at acceptance and ignored at other times. A `start` at any other time, or with a count outside that range, does nothing.
- R3: In normal mode each bit period lasts 2·HALF_CYC system clocks: HALF_CYC with `sclk` high, then HALF_CYC with `sclk` low. `sdi` changes exactly one system clock after `sclk` falls.
- R4: In normal mode, when `msb_first`=0, the bits presented at successive `sclk` rises are `load_word[0]`, `load_word[1]`, … up to `load_word[N-1]`. When `msb_first`=1, they are `load_word[N-1]` down to `load_word[0]`.
- R5: `sdo` is sampled in the last system clock of each high phase. The k-th bit read is stored in `rd_bits[k]`, and every `rd_bits` position at or above N reads 0.
- R6: `done` is high for exactly one system clock: the cycle in which `sclk` rises for the N-th time. Counting from the `start` edge, that cycle comes 2·HALF_CYC·N cycles later in normal mode and 3·HALF_CYC·N in triple mode.
- R7: In triple mode each bit period has three phases of HALF_CYC each: clock high, then clock low with `sdi`=1, then clock low with `sdi`=0. `sdo` is sampled at the end of each phase, and `load_word` has no effect.
- R8: In triple mode the stored bit is taken from the samples (first, second, third) as follows. If the second and third samples agree and differ from the first, the stored bit is the second sample; this covers 011 giving 1 and 100 giving 0. In every other case the stored bit is the first sample; this covers 000, 001, 010, 101, 110 and 111.
- R9: During a transfer, `sdi` never changes while `sclk` stays high, and every high or low phase of `sclk` lasts at least HALF_CYC system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a transfer (one-cycle pulse) |
| bit_count | input | CNT_W | Number of bits N, 1..MAX_BITS |
| load_word | input | MAX_BITS | Parallel source of the outgoing bits |
| msb_first | input | 1 | 1: send load_word[N-1] first; 0: send load_word[0] first |
| triple_mode | input | 1 | 1: three-sample read with vote; outgoing bits are 0 |
| sdo | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock to the device, high at rest |
| sdi | output | 1 | Serial data to the device |
| rd_bits | output | MAX_BITS | Read-back bits, index k is the k-th bit read |
| done | output | 1 | One-cycle pulse at the final clock rise |

## Verification
The bench models the device so that, bit by bit, it can show a clean value, an inverted or direct echo of `sdi` while the clock is low, or a false low or false high that clears when `sdi` moves. This produces all eight sample patterns. A design that sampled on the low phase would pick up the echo, and a design with the vote inverted would store the false level. It sends transfers of one bit and of MAX_BITS bits in both bit orders. A missing pre-alignment in MSB-first mode would show up as a wrong captured sequence, and an off-by-one in the last-bit test would show up as a wrong cycle count to `done`. The bench also pulses `start` during a transfer and issues counts of 0 and MAX_BITS+1. A design that did not guard these would restart or run away, which the bench sees in the clock line and in the cycle count.

// File: rtl/ss_pkg.sv
// Shared types for the serial shift engine.
package ss_pkg;
    typedef enum logic [1:0] {
        SS_IDLE,   // clock resting high, waiting for start
        SS_HIGH,   // clock high, sample near the end
        SS_LOW,    // clock low, data-in updated (triple: driven high)
        SS_LOW2    // triple mode only: clock low, data-in driven low
    } ss_state_e;
endpackage

// File: rtl/ss_phase_timer.sv
// Phase timer: counts HALF_CYC system clocks per phase and wraps, so
// consecutive phases chain without gaps.
// Assumes HALF_CYC >= 2 so the first and last cycle of a phase differ.
module ss_phase_timer #(
    parameter int HALF_CYC = 1250,
    localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic first,
    output logic last
);
    logic [TW-1:0] cnt;

    // Count while a transfer runs, hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == TW'(HALF_CYC - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign first = (cnt == '0);
    assign last  = (cnt == TW'(HALF_CYC - 1));
endmodule

// File: rtl/ss_tx_shifter.sv
// Outgoing bit source: loads the parallel word at start. In MSB-first mode
// it pre-aligns the word so that bit N-1 sits at the top. It then presents
// one bit per advance.
// Assumes count is 1..W when load is asserted.
module ss_tx_shifter #(
    parameter int W  = 138,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          msb_first,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  word,
    input  logic          advance,
    output logic          cur_bit
);
    logic [W-1:0]  sh_q;
    logic          msb_q;
    logic [CW-1:0] pad;

    assign pad = CW'(W) - count;

    // Load (with alignment) or step the shift register by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            msb_q <= 1'b0;
        end else if (load) begin
            sh_q  <= msb_first ? (word << pad) : word;
            msb_q <= msb_first;
        end else if (advance) begin
            sh_q  <= msb_q ? (sh_q << 1) : (sh_q >> 1);
        end
    end

    assign cur_bit = msb_q ? sh_q[W-1] : sh_q[0];
endmodule

// File: rtl/ss_bit_vote.sv
// Read-bit resolver. Normal mode keeps the clock-high sample. Triple mode
// takes the later pair of samples only when they agree with each other and
// disagree with the first sample.
module ss_bit_vote (
    input  logic triple,
    input  logic s_high,
    input  logic s_low_a,
    input  logic s_low_b,
    output logic bit_out
);
    logic later_wins;

    // Decide whether the later pair of samples overrides the first.
    always_comb begin
        later_wins = triple && (s_low_a == s_low_b) && (s_low_a != s_high);
        bit_out    = later_wins ? s_low_a : s_high;
    end
endmodule

// File: rtl/ser_shift_engine.sv
// Serial shift engine. Runs N bit periods on sclk/sdi/sdo, with the clock
// resting high, and captures read bits in arrival order. An optional
// three-sample vote is available for unreliable read-back bits.
// Assumes HALF_CYC >= 2 and sdo settles within one phase.
module ser_shift_engine
    import ss_pkg::*;
#(
    parameter int HALF_CYC = 1250,
    parameter int MAX_BITS = 138,
    localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CNT_W-1:0]    bit_count,
    input  logic [MAX_BITS-1:0] load_word,
    input  logic                msb_first,
    input  logic                triple_mode,
    input  logic                sdo,
    output logic                sclk,
    output logic                sdi,
    output logic [MAX_BITS-1:0] rd_bits,
    output logic                done
);
    ss_state_e           state;
    logic                busy;
    logic                accept;
    logic                ph_first, ph_last;
    logic                tx_bit, vote_bit;
    logic                tri_q, s0_q, s1_q;
    logic                last_bit;
    logic [CNT_W-1:0]    n_q, idx;
    logic [MAX_BITS-1:0] rd_q;

    assign busy     = (state != SS_IDLE);
    assign accept   = !busy && start && (bit_count != '0)
                      && (bit_count <= CNT_W'(MAX_BITS));
    assign last_bit = (idx == n_q - 1'b1);

    ss_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .first (ph_first),
        .last  (ph_last)
    );

    ss_tx_shifter #(.W(MAX_BITS), .CW(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .msb_first (msb_first),
        .count     (bit_count),
        .word      (load_word),
        .advance   (state == SS_LOW && ph_first && !tri_q),
        .cur_bit   (tx_bit)
    );

    ss_bit_vote u_vote (
        .triple  (tri_q),
        .s_high  (s0_q),
        .s_low_a (s1_q),
        .s_low_b (sdo),
        .bit_out (vote_bit)
    );

    // Bit-period sequencer: sample, lower, change data-in, raise, repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SS_IDLE;
            sclk  <= 1'b1;
            sdi   <= 1'b0;
            done  <= 1'b0;
            tri_q <= 1'b0;
            s0_q  <= 1'b0;
            s1_q  <= 1'b0;
            n_q   <= '0;
            idx   <= '0;
            rd_q  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SS_IDLE: begin
                    if (accept) begin
                        state <= SS_HIGH;
                        n_q   <= bit_count;
                        tri_q <= triple_mode;
                        idx   <= '0;
                        rd_q  <= '0;
                        if (triple_mode)
                            sdi <= 1'b0;
                    end
                end
                SS_HIGH: begin
                    if (ph_last) begin
                        s0_q  <= sdo;
                        sclk  <= 1'b0;
                        state <= SS_LOW;
                    end
                end
                SS_LOW: begin
                    if (ph_first)
                        sdi <= tri_q ? 1'b1 : tx_bit;
                    if (ph_last) begin
                        if (tri_q) begin
                            s1_q  <= sdo;
                            sdi   <= 1'b0;
                            state <= SS_LOW2;
                        end else begin
                            sclk      <= 1'b1;
                            rd_q[idx] <= s0_q;
                            idx       <= idx + 1'b1;
                            state     <= last_bit ? SS_IDLE : SS_HIGH;
                            done      <= last_bit;
                        end
                    end
                end
                SS_LOW2: begin
                    if (ph_last) begin
                        sclk      <= 1'b1;
                        rd_q[idx] <= vote_bit;
                        idx       <= idx + 1'b1;
                        state     <= last_bit ? SS_IDLE : SS_HIGH;
                        done      <= last_bit;
                    end
                end
                default: state <= SS_IDLE;
            endcase
        end
    end

    assign rd_bits = rd_q;
endmodule

// File: rtl/ss_engine_chk.sv
// Protocol checker for ser_shift_engine. It watches the serial pins, the
// internal busy flag and done. It is attached through bind below.
module ss_engine_chk #(
    parameter int HALF_CYC = 1250,
    parameter int MAX_BITS = 138,
    parameter int CNT_W    = 8,
    localparam int PW = $clog2(HALF_CYC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] bit_count,
    input logic             sclk,
    input logic             sdi,
    input logic             busy,
    input logic             done
);
    logic          prev_sclk;
    logic [PW-1:0] run_len;

    // Track how many cycles the previous sclk level has lasted (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sclk <= 1'b1;
            run_len   <= PW'(HALF_CYC);
        end else begin
            prev_sclk <= sclk;
            if (sclk != prev_sclk)
                run_len <= PW'(1);
            else if (run_len != PW'(HALF_CYC))
                run_len <= run_len + 1'b1;
        end
    end

    assert_idle_clock_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    assert_bad_count_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (bit_count == '0 || bit_count > CNT_W'(MAX_BITS))) |=> !busy);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(sclk));

    assert_end_gives_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_sdi_hold_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sclk && $past(sclk)) |-> $stable(sdi));

    assert_phase_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != prev_sclk) |-> (run_len >= PW'(HALF_CYC)));
endmodule

bind ser_shift_engine ss_engine_chk #(
    .HALF_CYC (HALF_CYC),
    .MAX_BITS (MAX_BITS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bit_count (bit_count),
    .sclk      (sclk),
    .sdi       (sdi),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_ser_shift_engine.sv
// Bench for ser_shift_engine: a device model with per-bit read faults,
// random transfers from a fixed seed, and directed corner cases.
module sim_ser_shift_engine;
    localparam int H  = 3;
    localparam int MB = 138;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] bit_count = '0;
    logic [MB-1:0] load_word = '0;
    logic          msb_first = 1'b0;
    logic          triple_mode = 1'b0;
    logic          sdo;
    logic          sclk, sdi, done;
    logic [MB-1:0] rd_bits;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ser_shift_engine #(.HALF_CYC(H), .MAX_BITS(MB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_count(bit_count),
        .load_word(load_word), .msb_first(msb_first), .triple_mode(triple_mode),
        .sdo(sdo), .sclk(sclk), .sdi(sdi), .rd_bits(rd_bits), .done(done)
    );

    // Device model. Fault kinds: 0 clean, 1 inverted echo of sdi while the
    // clock is low, 2 false low until sdi moves with the clock low,
    // 3 false high until sdi moves with the clock low, 4 direct echo while low.
    logic truth [MB];
    int   kind  [MB];
    logic cap   [MB];
    int   didx = 0;
    int   ncap = 0;
    int   gen  = 0;
    logic stuck = 1'b1;

    function automatic logic model_out(int k, logic c, logic d, logic st);
        if (k >= MB) return 1'b0;
        if (c) begin
            if (kind[k] == 2 && st) return 1'b0;
            if (kind[k] == 3 && st) return 1'b1;
            return truth[k];
        end
        case (kind[k])
            1: return ~d;
            4: return d;
            2: return st ? 1'b0 : truth[k];
            3: return st ? 1'b1 : truth[k];
            default: return truth[k];
        endcase
    endfunction

    always @(posedge sclk) begin
        if (ncap < MB) cap[ncap] = sdi;
        ncap++;
        didx++;
        stuck = 1'b1;
    end

    always @(sdi) if (sclk == 1'b0) stuck = 1'b0;

    always @(sclk or sdi or stuck or didx or gen)
        sdo = model_out(didx, sclk, sdi, stuck);

    // Bench-side monitor for R9: sdi must hold while sclk stays high.
    bit   act = 0, act_p = 0;
    logic sclk_p = 1'b1, sdi_p = 1'b0;
    int   hold_viol = 0;
    always @(negedge clk) begin
        if (act && act_p && sclk && sclk_p && (sdi !== sdi_p)) hold_viol++;
        act_p  = act;
        sclk_p = sclk;
        sdi_p  = sdi;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [MB-1:0] actual, input logic [MB-1:0] expected);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, actual, expected);
        end
    endtask

    function automatic logic exp_tx(logic [MB-1:0] w, int n, bit msb, int k);
        return msb ? w[n-1-k] : w[k];
    endfunction

    function automatic logic exp_rd(bit tri3, int k);
        if (tri3) return truth[k];
        if (kind[k] == 2) return 1'b0;
        if (kind[k] == 3) return 1'b1;
        return truth[k];
    endfunction

    function automatic logic [MB-1:0] rnd_word();
        logic [159:0] v;
        v = {$urandom, $urandom, $urandom, $urandom, $urandom};
        return v[MB-1:0];
    endfunction

    task automatic run_xfer(input int n, input logic [MB-1:0] w, input bit msb,
                            input bit tri3, input bit poke, input string tag);
        logic [MB-1:0] e_rd, e_cap, g_cap;
        int cyc, e_cyc;
        e_rd = '0; e_cap = '0; g_cap = '0;
        for (int k = 0; k < n; k++) begin
            e_rd[k]  = exp_rd(tri3, k);
            e_cap[k] = tri3 ? 1'b0 : exp_tx(w, n, msb, k);
        end
        e_cyc = (tri3 ? 3 : 2) * H * n + 1;
        didx = 0; ncap = 0; stuck = 1'b1; gen++;
        @(negedge clk);
        start = 1'b1; bit_count = CW'(n); load_word = w;
        msb_first = msb; triple_mode = tri3;
        @(negedge clk);
        start = 1'b0; act = 1;
        // Inputs change after acceptance and must have no effect (R2).
        load_word = ~w; msb_first = ~msb; triple_mode = ~tri3; bit_count = 8'd1;
        cyc = 1;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 5);
        end
        start = 1'b0;
        act = 0;
        chk(cyc == e_cyc, "R6", {tag, " cycles start to done"}, MB'(cyc), MB'(e_cyc));
        chk(rd_bits == e_rd, tri3 ? "R8" : "R5", {tag, " read bits"}, rd_bits, e_rd);
        for (int k = 0; k < n && k < MB; k++) g_cap[k] = cap[k];
        chk(ncap == n, "R3", {tag, " clock rises"}, MB'(ncap), MB'(n));
        chk(g_cap == e_cap, tri3 ? "R7" : "R4", {tag, " bits at rising edges"}, g_cap, e_cap);
        @(negedge clk);
        chk(!done && sclk, "R6", {tag, " done single cycle, clock back high"},
            MB'({done, sclk}), MB'(2'b01));
    endtask

    task automatic bad_start(input int n);
        bit moved = 0;
        @(negedge clk);
        start = 1'b1; bit_count = CW'(n);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4 * H; i++) begin
            @(negedge clk);
            if (!sclk || done) moved = 1;
        end
        chk(!moved, "R2", $sformatf("count %0d ignored", n), MB'(moved), MB'(0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [MB-1:0] w;
        int n;
        bit tri3, msb;
        void'($urandom(32'd20240611));
        for (int k = 0; k < MB; k++) begin truth[k] = 1'b0; kind[k] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sclk && !sdi && !done && rd_bits == '0, "R1", "reset state",
            MB'({sclk, sdi, done}), MB'(3'b100));

        // Directed: every fault kind with both truth values.
        for (int k = 0; k < MB; k++) begin kind[k] = k % 5; truth[k] = ((k / 5) % 2) != 0; end
        run_xfer(1, 138'h1, 1'b0, 1'b0, 1'b0, "n1 lsb");
        run_xfer(1, 138'h1, 1'b1, 1'b1, 1'b0, "n1 triple");
        run_xfer(MB, rnd_word(), 1'b1, 1'b0, 1'b0, "full msb");
        run_xfer(MB, rnd_word(), 1'b0, 1'b0, 1'b0, "full lsb");
        run_xfer(MB, rnd_word(), 1'b0, 1'b1, 1'b0, "full triple vote R8");
        run_xfer(10, rnd_word(), 1'b1, 1'b0, 1'b1, "start during transfer R2");
        chk(sclk, "R1", "idle clock high", MB'(sclk), MB'(1));
        bad_start(0);
        bad_start(MB + 1);

        // Random transfers.
        for (int t = 0; t < 16; t++) begin
            for (int k = 0; k < MB; k++) begin
                kind[k]  = $urandom_range(4, 0);
                truth[k] = $urandom_range(1, 0) != 0;
            end
            n    = $urandom_range(MB, 1);
            msb  = $urandom_range(1, 0) != 0;
            tri3 = $urandom_range(1, 0) != 0;
            w    = rnd_word();
            run_xfer(n, w, msb, tri3, 1'b0, $sformatf("random %0d", t));
        end

        chk(hold_viol == 0, "R9", "sdi changed while sclk high", MB'(hold_viol), MB'(0));
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule